// File: doc/BRIEF.md
# SPI Ethernet-Controller Command Monitor

This block passively observes a four-wire SPI link between a host and a small Ethernet controller. It drives nothing on the bus. Every SPI line first passes through a two-flop synchroniser into the system clock domain. Bits are taken on each rising serial clock (mode 0, MSB first) while chip-select is low. When chip-select rises, the frame is classified from its header byte and checked against the length and header rule for that command. The monitor then emits one result record on a valid/ready output.

The monitor keeps a model of the controller's two register-bank bits. It updates that model from register writes, bit-set commands and bit-clear commands aimed at the bank-select address. A system reset command returns both bits to unknown. Each record reports the bank that was in force when its transaction began, together with a flag saying whether that bank is known. It also carries the opcode class, the register address, the first data byte, the payload length and five warning flags.

Top module: `spi_netctl_monitor`

## Requirements
- R1: A frame that holds at least one complete byte produces exactly one record. Byte 0 is the header: bits 7:5 are the opcode, reported on `rec_opcode`, and bits 4:0 are the address, reported on `rec_addr`. A frame with no complete byte produces no record.
- R2: Opcode 3'b110 sets warning bit 0 (unknown command). No other opcode sets that bit.
- R3: Opcode 3'b000 (register read) must be 2 or 3 bytes long. Any other length sets warning bit 1 and gives data 0. A 2-byte read reports MISO byte 1 as data; a 3-byte read reports MISO byte 2.
- R4: The register-class check runs only when the bank is known. Per bank, a 32-bit parameter map (bit index bank*32+address) marks the registers that need a dummy byte. If such a register is read with a length other than 3, or any other register is read with a length other than 2, warning bit 4 is set.
- R5: Opcode 3'b001 (buffer read) needs the header to be exactly 0x3A, and opcode 3'b011 (buffer write) needs exactly 0x7A. Any other header sets warning bit 2. Data is MISO byte 1 for a buffer read and MOSI byte 1 for a buffer write, or 0 if the frame has a single byte. Buffer commands never set warning bit 1.
- R6: Opcodes 3'b010 (register write), 3'b100 (bit set) and 3'b101 (bit clear) must be exactly 2 bytes long, and 3'b111 (system reset) exactly 1 byte. Any other length sets warning bit 1. For the first three, data is MOSI byte 1 whenever the frame has at least 2 bytes.
- R7: `rec_len` equals the byte count minus one. The byte counter saturates at its all-ones value.
- R8: A valid-length register write to address 0x1F, in any bank, loads bank bit 0 and bank bit 1 from data bits 0 and 1 and marks both bits known.
- R9: A valid-length bit set to address 0x1F sets each bank bit whose mask bit is 1, and a bit clear clears each such bit. Either way the bit is marked known. Bank bits whose mask bit is 0 are unchanged.
- R10: The bank is known only when both bits are known. While it is unknown, `rec_bank_known` is 0 and `rec_bank` is 0, and any register opcode (000, 010, 100, 101) sets warning bit 3. Each record reports the bank as it stood before its own transaction.
- R11: A 1-byte system reset command returns both bank bits to unknown.
- R12: `rec_valid` stays high with all record fields unchanged until `rec_ready` is seen. A record that completes while one is still pending replaces it.
- R13: After reset, `rec_valid` is 0 and the bank is unknown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Observed serial clock |
| spi_cs_n | input | 1 | Observed chip-select, active low |
| spi_mosi | input | 1 | Observed host-to-controller data |
| spi_miso | input | 1 | Observed controller-to-host data |
| rec_valid | output | 1 | Record available |
| rec_ready | input | 1 | Record consumed |
| rec_opcode | output | 3 | Opcode class from header bits 7:5 |
| rec_addr | output | 5 | Register address from header bits 4:0 |
| rec_bank | output | 2 | Bank in force before the transaction (0 when unknown) |
| rec_bank_known | output | 1 | Both bank bits known |
| rec_data | output | 8 | First data byte as chosen per opcode |
| rec_len | output | 16 | Byte count minus one |
| rec_warn | output | 5 | Bit0 unknown opcode, bit1 length, bit2 header, bit3 bank unknown, bit4 register class |

## Verification
A record appears three system clocks after chip-select rises at the pins. Two of those cycles are the synchroniser and one is the output register. A bit reaches the capture logic two cycles after its serial-clock edge. The bench drives every bus line on the falling system clock, with four system clocks per serial half-period. After raising chip-select it polls `rec_valid` on falling edges for up to twelve cycles, and it uses the same window to confirm that an empty frame yields nothing. Bank side effects are judged through the bank fields of later records. The back-pressure check holds `rec_ready` low for twenty cycles and compares the record before and after.

// File: rtl/spimon_pkg.sv
package spimon_pkg;
  typedef enum logic [2:0] {
    OP_RDREG   = 3'b000,
    OP_RDBUF   = 3'b001,
    OP_WRREG   = 3'b010,
    OP_WRBUF   = 3'b011,
    OP_SETBITS = 3'b100,
    OP_CLRBITS = 3'b101,
    OP_UNDEF   = 3'b110,
    OP_SYSRST  = 3'b111
  } op_e;

  localparam int NWARN   = 5;
  localparam int W_UNKOP = 0;
  localparam int W_LEN   = 1;
  localparam int W_HDR   = 2;
  localparam int W_BANK  = 3;
  localparam int W_CLASS = 4;

  localparam logic [4:0] BANKSEL_ADDR = 5'h1F;
  localparam logic [7:0] HDR_RDBUF    = 8'h3A;
  localparam logic [7:0] HDR_WRBUF    = 8'h7A;
endpackage

// File: rtl/spimon_sync.sv
module spimon_sync #(
  parameter int WIDTH = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stage;

  always_ff @(posedge clk) begin
    if (rst) stage <= {STAGES{RST_VAL}};
    else     stage <= {stage[STAGES-2:0], d};
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/spimon_capture.sv
module spimon_capture #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sclk,
  input  logic             cs_n,
  input  logic             mosi,
  input  logic             miso,
  output logic             frame_end,
  output logic [LEN_W-1:0] nbytes,
  output logic [7:0]       hdr,
  output logic [7:0]       mosi1,
  output logic [7:0]       miso1,
  output logic [7:0]       miso2
);
  localparam logic [LEN_W-1:0] CNT_MAX = {LEN_W{1'b1}};

  logic       sclk_q, cs_q;
  logic [2:0] bitc;
  logic [6:0] sh_mo, sh_mi;
  logic [7:0] byte_mo, byte_mi;
  logic       sclk_rise, cs_fall;

  assign sclk_rise = sclk & ~sclk_q;
  assign cs_fall   = ~cs_n & cs_q;
  assign frame_end = cs_n & ~cs_q;
  assign byte_mo   = {sh_mo, mosi};
  assign byte_mi   = {sh_mi, miso};

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
      bitc   <= '0;
      sh_mo  <= '0;
      sh_mi  <= '0;
      nbytes <= '0;
      hdr    <= '0;
      mosi1  <= '0;
      miso1  <= '0;
      miso2  <= '0;
    end else begin
      sclk_q <= sclk;
      cs_q   <= cs_n;
      if (cs_fall) begin
        bitc   <= '0;
        nbytes <= '0;
      end else if (!cs_n && sclk_rise) begin
        sh_mo <= byte_mo[6:0];
        sh_mi <= byte_mi[6:0];
        bitc  <= bitc + 3'd1;
        if (bitc == 3'd7) begin
          if (nbytes == LEN_W'(0)) hdr <= byte_mo;
          if (nbytes == LEN_W'(1)) begin
            mosi1 <= byte_mo;
            miso1 <= byte_mi;
          end
          if (nbytes == LEN_W'(2)) miso2 <= byte_mi;
          if (nbytes != CNT_MAX) nbytes <= nbytes + LEN_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/spimon_eval.sv
module spimon_eval
  import spimon_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int NBANK_BITS = 2,
  parameter int NREG = 32,
  parameter logic [(1<<NBANK_BITS)*NREG-1:0] CLASS_MAP = '0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  frame_end,
  input  logic [LEN_W-1:0]      nbytes,
  input  logic [7:0]            hdr,
  input  logic [7:0]            mosi1,
  input  logic [7:0]            miso1,
  input  logic [7:0]            miso2,
  output logic                  push,
  output op_e                   op,
  output logic [4:0]            addr,
  output logic [NBANK_BITS-1:0] bank,
  output logic                  bank_known,
  output logic [7:0]            data,
  output logic [LEN_W-1:0]      len,
  output logic [NWARN-1:0]      warn
);
  localparam int IDX_W = NBANK_BITS + 5;

  logic [NBANK_BITS-1:0] bbit, bknown;
  logic n1, n2, n3, ge2, is_reg, dummy_cls, on_sel;
  logic [NBANK_BITS-1:0] mask;

  assign op         = op_e'(hdr[7:5]);
  assign addr       = hdr[4:0];
  assign bank_known = &bknown;
  assign bank       = bank_known ? bbit : '0;
  assign n1         = (nbytes == LEN_W'(1));
  assign n2         = (nbytes == LEN_W'(2));
  assign n3         = (nbytes == LEN_W'(3));
  assign ge2        = (nbytes >= LEN_W'(2));
  assign len        = nbytes - LEN_W'(1);
  assign push       = frame_end && (nbytes != '0);
  assign dummy_cls  = CLASS_MAP[IDX_W'({bbit, addr})];
  assign on_sel     = (addr == BANKSEL_ADDR) && n2;
  assign mask       = mosi1[NBANK_BITS-1:0];
  assign is_reg     = (op == OP_RDREG) || (op == OP_WRREG) ||
                      (op == OP_SETBITS) || (op == OP_CLRBITS);

  always_comb begin
    warn = '0;
    data = '0;
    case (op)
      OP_RDREG: begin
        if (!(n2 || n3)) warn[W_LEN] = 1'b1;
        else begin
          if (bank_known && (dummy_cls != n3)) warn[W_CLASS] = 1'b1;
          data = n3 ? miso2 : miso1;
        end
      end
      OP_RDBUF: begin
        if (hdr != HDR_RDBUF) warn[W_HDR] = 1'b1;
        if (ge2) data = miso1;
      end
      OP_WRBUF: begin
        if (hdr != HDR_WRBUF) warn[W_HDR] = 1'b1;
        if (ge2) data = mosi1;
      end
      OP_WRREG, OP_SETBITS, OP_CLRBITS: begin
        if (!n2) warn[W_LEN] = 1'b1;
        if (ge2) data = mosi1;
      end
      OP_UNDEF:  warn[W_UNKOP] = 1'b1;
      OP_SYSRST: if (!n1) warn[W_LEN] = 1'b1;
      default: ;
    endcase
    if (is_reg && !bank_known) warn[W_BANK] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bbit   <= '0;
      bknown <= '0;
    end else if (push) begin
      case (op)
        OP_WRREG: if (on_sel) begin
          bbit   <= mask;
          bknown <= '1;
        end
        OP_SETBITS: if (on_sel) begin
          bbit   <= bbit | mask;
          bknown <= bknown | mask;
        end
        OP_CLRBITS: if (on_sel) begin
          bbit   <= bbit & ~mask;
          bknown <= bknown | mask;
        end
        OP_SYSRST: if (n1) begin
          bbit   <= '0;
          bknown <= '0;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/spi_netctl_monitor.sv
module spi_netctl_monitor
  import spimon_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int SYNC_STAGES = 2,
  parameter logic [127:0] CLASS_MAP = {32'h0000_043F, 32'h03FF_FFFF, 32'h0, 32'h0}
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             spi_sclk,
  input  logic             spi_cs_n,
  input  logic             spi_mosi,
  input  logic             spi_miso,
  output logic             rec_valid,
  input  logic             rec_ready,
  output logic [2:0]       rec_opcode,
  output logic [4:0]       rec_addr,
  output logic [1:0]       rec_bank,
  output logic             rec_bank_known,
  output logic [7:0]       rec_data,
  output logic [LEN_W-1:0] rec_len,
  output logic [4:0]       rec_warn
);
  logic [3:0] bus_s;
  logic frame_end, evt_push, e_known;
  logic [LEN_W-1:0] nbytes, e_len;
  logic [7:0] hdr, mosi1, miso1, miso2, e_data;
  op_e e_op;
  logic [4:0] e_addr;
  logic [1:0] e_bank;
  logic [NWARN-1:0] e_warn;

  spimon_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0100)) u_sync (
    .clk(clk), .rst(rst),
    .d({spi_sclk, spi_cs_n, spi_mosi, spi_miso}),
    .q(bus_s)
  );

  spimon_capture #(.LEN_W(LEN_W)) u_cap (
    .clk(clk), .rst(rst),
    .sclk(bus_s[3]), .cs_n(bus_s[2]), .mosi(bus_s[1]), .miso(bus_s[0]),
    .frame_end(frame_end), .nbytes(nbytes),
    .hdr(hdr), .mosi1(mosi1), .miso1(miso1), .miso2(miso2)
  );

  spimon_eval #(.LEN_W(LEN_W), .NBANK_BITS(2), .NREG(32), .CLASS_MAP(CLASS_MAP)) u_eval (
    .clk(clk), .rst(rst),
    .frame_end(frame_end), .nbytes(nbytes),
    .hdr(hdr), .mosi1(mosi1), .miso1(miso1), .miso2(miso2),
    .push(evt_push), .op(e_op), .addr(e_addr), .bank(e_bank),
    .bank_known(e_known), .data(e_data), .len(e_len), .warn(e_warn)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rec_valid      <= 1'b0;
      rec_opcode     <= '0;
      rec_addr       <= '0;
      rec_bank       <= '0;
      rec_bank_known <= 1'b0;
      rec_data       <= '0;
      rec_len        <= '0;
      rec_warn       <= '0;
    end else if (evt_push) begin
      rec_valid      <= 1'b1;
      rec_opcode     <= e_op;
      rec_addr       <= e_addr;
      rec_bank       <= e_bank;
      rec_bank_known <= e_known;
      rec_data       <= e_data;
      rec_len        <= e_len;
      rec_warn       <= e_warn;
    end else if (rec_ready) begin
      rec_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/spimon_chk.sv
module spimon_chk #(
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             push,
  input logic             rec_valid,
  input logic             rec_ready,
  input logic [2:0]       rec_opcode,
  input logic [1:0]       rec_bank,
  input logic             rec_bank_known,
  input logic [7:0]       rec_data,
  input logic [LEN_W-1:0] rec_len,
  input logic [4:0]       rec_warn
);
  // R12
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    rec_valid && !rec_ready && !push |=> rec_valid && $stable(rec_opcode) &&
      $stable(rec_data) && $stable(rec_len) && $stable(rec_warn));

  // R2
  undef_warn_chk: assert property (@(posedge clk) disable iff (rst)
    rec_valid && rec_opcode == 3'b110 |-> rec_warn[0]);

  // R2
  undef_only_chk: assert property (@(posedge clk) disable iff (rst)
    rec_valid && rec_warn[0] |-> rec_opcode == 3'b110);

  // R5
  buf_nolen_chk: assert property (@(posedge clk) disable iff (rst)
    rec_valid && (rec_opcode == 3'b001 || rec_opcode == 3'b011) |-> !rec_warn[1] && !rec_warn[3]);

  // R10
  unknown_bank_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rec_valid && !rec_bank_known |-> rec_bank == 2'b00);

  // R10
  known_bank_nowarn_chk: assert property (@(posedge clk) disable iff (rst)
    rec_valid && rec_bank_known |-> !rec_warn[3]);

  // R4
  class_needs_bank_chk: assert property (@(posedge clk) disable iff (rst)
    rec_valid && rec_warn[4] |-> rec_bank_known && rec_opcode == 3'b000);
endmodule

bind spi_netctl_monitor spimon_chk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst(rst), .push(evt_push),
  .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_opcode(rec_opcode),
  .rec_bank(rec_bank), .rec_bank_known(rec_bank_known), .rec_data(rec_data),
  .rec_len(rec_len), .rec_warn(rec_warn)
);

// File: tb/sim_spi_netctl_monitor.sv
module sim_spi_netctl_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;
  localparam logic [127:0] MAP = {32'h0000_043F, 32'h03FF_FFFF, 32'h0, 32'h0};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0, spi_miso = 1'b0;
  logic rec_ready = 1'b1;
  logic rec_valid, rec_bank_known;
  logic [2:0] rec_opcode;
  logic [4:0] rec_addr, rec_warn;
  logic [1:0] rec_bank;
  logic [7:0] rec_data;
  logic [15:0] rec_len;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [7:0] tx_mo [16];
  logic [7:0] tx_mi [16];
  logic [1:0] mb = 2'b00, mk = 2'b00;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_netctl_monitor u0 (
    .clk(clk), .rst(rst), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .rec_valid(rec_valid),
    .rec_ready(rec_ready), .rec_opcode(rec_opcode), .rec_addr(rec_addr),
    .rec_bank(rec_bank), .rec_bank_known(rec_bank_known), .rec_data(rec_data),
    .rec_len(rec_len), .rec_warn(rec_warn)
  );

  function automatic logic [39:0] act_rec();
    return {rec_opcode, rec_addr, rec_bank, rec_bank_known, rec_data, rec_len, rec_warn};
  endfunction

  task automatic check(bit ok, string req, string what, logic [39:0] act, logic [39:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Expected record from the requirements; updates the bank model afterwards.
  task automatic model(int n, output logic [39:0] e);
    logic [2:0] op; logic [4:0] ad; logic kn; logic [1:0] bk;
    logic [4:0] w; logic [7:0] d; logic [15:0] ln; logic cls; logic [1:0] m;
    op = tx_mo[0][7:5]; ad = tx_mo[0][4:0];
    kn = &mk; bk = kn ? mb : 2'b00; w = '0; d = '0; ln = 16'(n - 1);
    cls = MAP[{mb, ad}]; m = tx_mo[1][1:0];
    case (op)
      3'b000: if (n != 2 && n != 3) w[1] = 1; else begin   // R3 R4
        if (kn && (cls != (n == 3))) w[4] = 1;
        d = (n == 3) ? tx_mi[2] : tx_mi[1];
      end
      3'b001: begin if (tx_mo[0] != 8'h3A) w[2] = 1; if (n >= 2) d = tx_mi[1]; end // R5
      3'b011: begin if (tx_mo[0] != 8'h7A) w[2] = 1; if (n >= 2) d = tx_mo[1]; end
      3'b110: w[0] = 1;                                      // R2
      3'b111: if (n != 1) w[1] = 1;                          // R6
      default: begin if (n != 2) w[1] = 1; if (n >= 2) d = tx_mo[1]; end
    endcase
    if ((op == 0 || op == 2 || op == 4 || op == 5) && !kn) w[3] = 1; // R10
    e = {op, ad, bk, kn, d, ln, w};
    if (ad == 5'h1F && n == 2) begin                         // R8 R9
      if (op == 3'b010) begin mb = m; mk = 2'b11; end
      if (op == 3'b100) begin mb = mb | m; mk = mk | m; end
      if (op == 3'b101) begin mb = mb & ~m; mk = mk | m; end
    end
    if (op == 3'b111 && n == 1) begin mb = 0; mk = 0; end    // R11
  endtask

  task automatic spi_frame(int n);
    @(negedge clk); spi_cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      for (int b = 7; b >= 0; b--) begin
        spi_mosi = tx_mo[i][b]; spi_miso = tx_mi[i][b];
        repeat (HALF) @(negedge clk); spi_sclk = 1'b1;
        repeat (HALF) @(negedge clk); spi_sclk = 1'b0;
      end
    end
    repeat (HALF) @(negedge clk); spi_cs_n = 1'b1;
  endtask

  task automatic await_rec(output bit got);
    got = 0;
    for (int c = 0; c < 12 && !got; c++) begin
      @(negedge clk);
      if (rec_valid) got = 1;
    end
  endtask

  task automatic run(int n, string req);
    logic [39:0] e; bit got;
    model(n, e);
    spi_frame(n);
    await_rec(got);
    if (n == 0) check(!got, req, "record from empty frame", 40'(got), 40'd0);
    else begin
      check(got, req, "record present", 40'(got), 40'd1);
      if (got) check(act_rec() == e, req, "record fields", act_rec(), e);
    end
    repeat (4 * HALF) @(negedge clk);
  endtask

  task automatic set(logic [7:0] a, logic [7:0] b, logic [7:0] c, logic [7:0] d);
    tx_mo[0] = a; tx_mo[1] = b; tx_mo[2] = c; tx_mo[3] = d;
    tx_mi[0] = 8'h11; tx_mi[1] = 8'hA5; tx_mi[2] = 8'hC3; tx_mi[3] = 8'h7E;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [39:0] held;
    void'($urandom(32'd2024));
    repeat (5) @(negedge clk); rst = 1'b0;
    @(negedge clk);
    // R13 reset state
    check(rec_valid == 1'b0, "R13", "valid after reset", 40'(rec_valid), 40'd0);

    set(8'h00, 8'h00, 0, 0); run(2, "R10");   // read, bank unknown
    set(8'h5F, 8'h02, 0, 0); run(2, "R8");    // write bank-select -> bank 2
    set(8'h00, 8'h00, 0, 0); run(3, "R4");    // dummy-class read, 3 bytes ok
    set(8'h00, 8'h00, 0, 0); run(2, "R4");    // dummy-class read, 2 bytes: class warn
    set(8'h1E, 8'h00, 0, 0); run(3, "R4");    // normal reg, 3 bytes: class warn
    set(8'h1E, 8'h00, 0, 0); run(2, "R3");    // normal reg, data byte 1
    set(8'h00, 8'h00, 0, 0); run(4, "R3");    // bad length
    set(8'hBF, 8'h02, 0, 0); run(2, "R9");    // clear bit1 -> bank 0
    set(8'h9F, 8'h01, 0, 0); run(2, "R9");    // set bit0 -> bank 1
    set(8'h5F, 8'h03, 8'h00, 0); run(3, "R6"); // bad length write: no bank change
    set(8'h00, 8'h00, 0, 0); run(2, "R8");    // observe bank 1 still
    set(8'hC5, 8'h00, 0, 0); run(1, "R2");    // unknown opcode
    set(8'h3A, 8'h00, 8'h00, 8'h00); run(4, "R7"); // buffer read, len 3
    set(8'h3B, 8'h00, 0, 0); run(2, "R5");    // bad header
    set(8'h7A, 8'h9C, 8'h01, 0); run(3, "R5"); // buffer write
    set(8'h7A, 0, 0, 0); run(1, "R5");        // buffer write, header only
    set(8'hFF, 8'h00, 0, 0); run(2, "R6");    // reset cmd bad length: bank kept
    set(8'h00, 8'h00, 0, 0); run(2, "R11");   // bank still known
    set(8'hFF, 0, 0, 0); run(1, "R11");       // valid reset
    set(8'h00, 8'h00, 0, 0); run(2, "R11");   // bank unknown again
    set(8'h9F, 8'h01, 0, 0); run(2, "R9");    // only bit0 known
    set(8'h00, 8'h00, 0, 0); run(3, "R10");   // still unknown: no class check
    run(0, "R1");                             // empty frame

    // R12 back-pressure hold
    rec_ready = 1'b0;
    set(8'h7A, 8'h44, 0, 0); run(2, "R12");
    held = act_rec();
    repeat (20) @(negedge clk);
    check(rec_valid == 1'b1, "R12", "valid held", 40'(rec_valid), 40'd1);
    check(act_rec() == held, "R12", "fields held", act_rec(), held);
    rec_ready = 1'b1;
    repeat (2) @(negedge clk);
    check(rec_valid == 1'b0, "R12", "valid drops after ready", 40'(rec_valid), 40'd0);

    // R1 random mix
    for (int k = 0; k < 60; k++) begin
      int n;
      logic [2:0] op;
      op = 3'($urandom_range(0, 7));
      n = $urandom_range(0, 5);
      for (int i = 0; i < 16; i++) begin
        tx_mo[i] = 8'($urandom); tx_mi[i] = 8'($urandom);
      end
      tx_mo[0][7:5] = op;
      if ($urandom_range(0, 2) == 0) tx_mo[0][4:0] = 5'h1F;
      if (op == 3'b001 && $urandom_range(0, 1) == 1) tx_mo[0] = 8'h3A;
      if (op == 3'b011 && $urandom_range(0, 1) == 1) tx_mo[0] = 8'h7A;
      run(n, "R1");
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule